// File: doc/BRIEF.md
# Packed Unsigned Multiply-High Unit

This block is a 256-bit vector datapath stage that treats each of its two source operands as sixteen 16-bit unsigned lanes. For every active lane it forms the full 32-bit unsigned product of the two lane values and keeps only the upper 16 bits of that product as the lane result. The result is registered, so it appears one clock after the request.

A 2-bit width selector decides what happens to the top 128 bits of the destination. In the two narrow settings only the low eight lanes are multiplied. The top half is then either carried over from the prior destination value, which arrives on its own input, or forced to zero. In the wide setting all sixteen lanes are multiplied. The surrounding pipeline supplies the operands, the prior destination and a one-cycle request strobe, and it picks up the registered result together with its valid flag.

Top module: `pmh_unit`

## Requirements
- R1: For every computed lane i, result bits [16i+15:16i] equal bits [31:16] of the 32-bit unsigned product of src_a[16i+15:16i] and src_b[16i+15:16i].
- R2: Both operands are unsigned, so lane values 0xFFFF and 0xFFFF give the lane result 0xFFFE.
- R3: With mode 2'b00 (narrow, keep), result bits [255:128] equal dst_old[255:128] as it was sampled with the request.
- R4: With mode 2'b01 (narrow, clear), result bits [255:128] are zero.
- R5: With mode 2'b10 (wide), all sixteen lanes, bits [255:0], are multiply-high results.
- R6: Mode 2'b11 is reserved and produces the same result as mode 2'b10.
- R7: Lanes 0 to 7 (bits [127:0]) are multiply-high results in every mode, and dst_old never affects them.
- R8: When in_vld is high at a rising clock edge, res_vld is high after that edge and res holds the result of that request. When in_vld is low, res_vld is low after the edge.
- R9: While rst_n is low, res_vld and res are zero.
- R10: A clock edge with in_vld low leaves res unchanged, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Request strobe, one cycle per operation |
| mode | input | 2 | Width selector: 00 narrow keep, 01 narrow clear, 10 wide, 11 wide |
| src_a | input | 256 | First source, sixteen 16-bit lanes |
| src_b | input | 256 | Second source, sixteen 16-bit lanes |
| dst_old | input | 256 | Prior destination value, used for the top half in keep mode |
| res | output | 256 | Registered multiply-high result |
| res_vld | output | 1 | High one cycle after an accepted request |

## Verification
The assertions assume that rst_n is released away from a clock edge and that mode, the sources and dst_old are stable and known whenever in_vld is sampled high. The bench meets this by changing every input on the falling clock edge only. It holds reset across several edges and leaves the strobe low until reset is released. All four mode codes are driven with known values. Corner operands such as all-ones lanes and single active lanes are mixed into the random sequence without breaking these conditions.

// File: rtl/pmh_pkg.sv
package pmh_pkg;
  localparam int unsigned LANE_W    = 16;
  localparam int unsigned VEC_W     = 256;
  localparam int unsigned NUM_LANES = VEC_W / LANE_W;
  localparam int unsigned HALF_LANE = NUM_LANES / 2;

  typedef enum logic [1:0] {
    WM_NARROW_KEEP = 2'b00,
    WM_NARROW_CLR  = 2'b01,
    WM_WIDE        = 2'b10,
    WM_WIDE_RSVD   = 2'b11
  } width_mode_e;
endpackage

// File: rtl/pmh_lane.sv
module pmh_lane #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] prod_hi
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] prod_full;

  always_comb begin
    prod_full = {{W{1'b0}}, op_a} * {{W{1'b0}}, op_b};
    prod_hi   = prod_full[PW-1:W];
  end
endmodule

// File: rtl/pmh_upper_sel.sv
module pmh_upper_sel
  import pmh_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  width_mode_e  wmode,
  input  logic [W-1:0] mul_hi,
  input  logic [W-1:0] old_lane,
  output logic [W-1:0] lane_out
);
  always_comb begin
    unique case (wmode)
      WM_NARROW_KEEP: lane_out = old_lane;
      WM_NARROW_CLR:  lane_out = '0;
      default:        lane_out = mul_hi;
    endcase
  end
endmodule

// File: rtl/pmh_unit.sv
module pmh_unit
  import pmh_pkg::*;
#(
  parameter int unsigned P_LANE_W = LANE_W,
  parameter int unsigned P_VEC_W  = VEC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic [1:0]         mode,
  input  logic [P_VEC_W-1:0] src_a,
  input  logic [P_VEC_W-1:0] src_b,
  input  logic [P_VEC_W-1:0] dst_old,
  output logic [P_VEC_W-1:0] res,
  output logic               res_vld
);
  localparam int unsigned LANES = P_VEC_W / P_LANE_W;
  localparam int unsigned LOW_N = LANES / 2;

  width_mode_e        wmode;
  logic [P_VEC_W-1:0] res_nxt;
  logic               vld_nxt;
  logic               res_en;

  assign wmode = width_mode_e'(mode);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [P_LANE_W-1:0] hi;

    pmh_lane #(.W(P_LANE_W)) u_mul (
      .op_a    (src_a[g*P_LANE_W +: P_LANE_W]),
      .op_b    (src_b[g*P_LANE_W +: P_LANE_W]),
      .prod_hi (hi)
    );

    if (g < LOW_N) begin : g_low
      assign res_nxt[g*P_LANE_W +: P_LANE_W] = hi;
    end else begin : g_high
      pmh_upper_sel #(.W(P_LANE_W)) u_sel (
        .wmode    (wmode),
        .mul_hi   (hi),
        .old_lane (dst_old[g*P_LANE_W +: P_LANE_W]),
        .lane_out (res_nxt[g*P_LANE_W +: P_LANE_W])
      );
    end
  end

  always_comb begin
    res_en  = in_vld;
    vld_nxt = in_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld <= 1'b0;
    end else begin
      res_vld <= vld_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res <= '0;
    end else if (res_en) begin
      res <= res_nxt;
    end
  end
endmodule

// File: rtl/pmh_unit_chk.sv
module pmh_unit_chk #(
  parameter int unsigned P_VEC_W = 256
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_vld,
  input logic [1:0]         mode,
  input logic [P_VEC_W-1:0] src_a,
  input logic [P_VEC_W-1:0] src_b,
  input logic [P_VEC_W-1:0] dst_old,
  input logic [P_VEC_W-1:0] res,
  input logic               res_vld
);
  localparam int unsigned HB = P_VEC_W / 2;

  assert_vld_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> res_vld);

  assert_idle_no_vld_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !res_vld);

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(res));

  assert_keep_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && mode == 2'b00) |=> (res[P_VEC_W-1:HB] == $past(dst_old[P_VEC_W-1:HB])));

  assert_clear_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && mode == 2'b01) |=> (res[P_VEC_W-1:HB] == '0));

  assert_all_ones_lane0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && src_a[15:0] == 16'hFFFF && src_b[15:0] == 16'hFFFF) |=> (res[15:0] == 16'hFFFE));
endmodule

bind pmh_unit pmh_unit_chk #(.P_VEC_W(P_VEC_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_vld  (in_vld),
  .mode    (mode),
  .src_a   (src_a),
  .src_b   (src_b),
  .dst_old (dst_old),
  .res     (res),
  .res_vld (res_vld)
);

// File: tb/sim_pmh_unit.sv
`timescale 1ns/1ps
module sim_pmh_unit;
  logic         clk;
  logic         rst_n;
  logic         in_vld;
  logic [1:0]   mode;
  logic [255:0] src_a, src_b, dst_old;
  logic [255:0] res;
  logic         res_vld;

  int n_chk;
  int n_fail;
  bit done;

  pmh_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .mode(mode),
    .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
    .res(res), .res_vld(res_vld)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [255:0] model(input logic [255:0] a, input logic [255:0] b,
                                         input logic [255:0] old, input logic [1:0] m);
    logic [255:0] r;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] p;
      p = {16'h0, a[16*i +: 16]} * {16'h0, b[16*i +: 16]};
      if (i >= 8 && m == 2'b00)      r[16*i +: 16] = old[16*i +: 16];
      else if (i >= 8 && m == 2'b01) r[16*i +: 16] = 16'h0;
      else                           r[16*i +: 16] = p[31:16];
    end
    return r;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [255:0] a, input logic [255:0] b,
                     input logic [255:0] old, input logic [1:0] m);
    logic [255:0] exp;
    string tu;
    exp = model(a, b, old, m);
    @(negedge clk);
    src_a = a; src_b = b; dst_old = old; mode = m; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    case (m)
      2'b00: tu = "R3";
      2'b01: tu = "R4";
      2'b10: tu = "R5";
      default: tu = "R6";
    endcase
    check("R8 res_vld", {255'h0, res_vld}, 256'h1);
    check("R7 R1 low half", {128'h0, res[127:0]}, {128'h0, exp[127:0]});
    check({tu, " upper half"}, {128'h0, res[255:128]}, {128'h0, exp[255:128]});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [255:0] held;
    logic [255:0] ones;
    logic [255:0] sl;
    n_chk = 0; n_fail = 0; done = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_vld = 1'b0; mode = 2'b00;
    src_a = '0; src_b = '0; dst_old = '0;
    repeat (3) @(negedge clk);
    check("R9 res_vld in reset", {255'h0, res_vld}, 256'h0);
    check("R9 res in reset", res, 256'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 idle res_vld", {255'h0, res_vld}, 256'h0);

    ones = '1;
    for (int m = 0; m < 4; m++) begin
      run(ones, ones, rnd256(), 2'(m));
      check("R2 ffff*ffff lane0", {240'h0, res[15:0]}, {240'h0, 16'hFFFE});
      run('0, ones, rnd256(), 2'(m));
      run(rnd256(), rnd256(), ones, 2'(m));
    end

    sl = '0; sl[5*16 +: 16] = 16'hC350;
    run(sl, ones, ones, 2'b10);
    check("R1 single lane 5", {240'h0, res[5*16 +: 16]}, {240'h0, 16'hC34F});
    sl = '0; sl[13*16 +: 16] = 16'h8000;
    run(sl, {16{16'h0004}}, '0, 2'b10);
    check("R5 single lane 13", {240'h0, res[13*16 +: 16]}, {240'h0, 16'h0002});
    run(sl, {16{16'h0004}}, ones, 2'b11);
    check("R6 reserved lane 13", {240'h0, res[13*16 +: 16]}, {240'h0, 16'h0002});

    held = res;
    @(negedge clk);
    src_a = rnd256(); src_b = rnd256(); dst_old = rnd256(); mode = 2'b01;
    @(negedge clk);
    check("R10 hold res", res, held);
    check("R8 no vld when idle", {255'h0, res_vld}, 256'h0);

    for (int n = 0; n < 200; n++) begin
      run(rnd256(), rnd256(), rnd256(), 2'($urandom_range(0, 3)));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule